// File: doc/BRIEF.md
# Partitioned SIMD Lane Bit-Slicer

This block takes a 64-bit word that is split into eight 8-bit partitions. It reads that word as a vector of equal-width elements, and a two-bit mode input picks the width: eight 8-bit lanes, four 16-bit lanes, two 32-bit lanes or one 64-bit lane. It cuts the same fixed bit range out of every element. The range is set by the compile-time parameters `SL_LO` (included) and `SL_HI` (excluded). Every element yields a slice of exactly `SL_HI - SL_LO` bits, whatever its width.

The result keeps one slice-wide field per 8-bit partition, so its layout does not depend on the mode. An element that spans several partitions places its slice in the field of its lowest partition. The fields of its upper partitions are forced to zero as padding. Alongside the data, the block emits a partition-boundary mask for the sliced word, so that downstream lane-aware logic can tell where elements begin. With `OUT_REG` set, both outputs pass through a register stage with one cycle of latency.

Top module: `simd_lane_slicer`

## Requirements
- R1: The data output is `NPART * (SL_HI - SL_LO)` bits wide, which is 24 bits for the default 3-bit slice, and field p occupies output bits [3p, 3p+3).
- R2: In every mode, field 0 equals input bits [SL_LO, SL_HI).
- R3: With mode 0 (8-bit elements), field p equals input bits [8p+SL_LO, 8p+SL_HI) for every p from 0 to 7.
- R4: With mode 1 (16-bit elements), field 2k equals input bits [16k+SL_LO, 16k+SL_HI) and every odd field is zero.
- R5: With mode 2 (32-bit elements), field 0 takes input bits [SL_LO, SL_HI), field 4 takes input bits [32+SL_LO, 32+SL_HI), and fields 1–3 and 5–7 are zero.
- R6: With mode 3 (one 64-bit element), only field 0 carries data and fields 1–7 are zero.
- R7: Bit b of the 7-bit partition mask marks the boundary between partitions b and b+1. It is set exactly when an element boundary lies there. The expected masks are 7'b1111111 in mode 0, 7'b0101010 in mode 1, 7'b0001000 in mode 2 and 7'b0000000 in mode 3.
- R8: With `OUT_REG` = 1, both outputs show the inputs sampled at the previous rising clock edge. While `rst_n` is low, both outputs are zero.
- R9: Input bits outside every element's slice range have no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Element width: 0 = 8-bit, 1 = 16-bit, 2 = 32-bit, 3 = 64-bit |
| din | input | NPART*PART_W | Partitioned input word |
| dout | output | NPART*(SL_HI-SL_LO) | One slice field per partition; padding fields are zero |
| part_mask | output | NPART-1 | Element-boundary mask for the sliced layout |

## Verification
The assertions assume that `mode` and `din` are stable and defined at every rising edge once reset is released. They also assume that the slice bounds fit inside one partition, and they compare the registered outputs with the inputs from one edge earlier. The stimulus meets these assumptions by changing the inputs only on falling edges and by holding them steady through reset. It uses the default bounds, which fit in a byte. The stimulus covers each of the four defined mode codes with random words, all-ones words and words that set only the bits outside the slice.

// File: rtl/simd_slice_pkg.sv
package simd_slice_pkg;

  typedef enum logic [1:0] {
    EW8  = 2'd0,
    EW16 = 2'd1,
    EW32 = 2'd2,
    EW64 = 2'd3
  } ew_mode_e;

  // Number of partitions spanned by one element in a given mode.
  function automatic int unsigned parts_per_elem(input logic [1:0] m);
    return 32'd1 << m;
  endfunction

endpackage

// File: rtl/simd_part_mask.sv
module simd_part_mask #(
  parameter int unsigned NPART = 8
) (
  input  logic [1:0]       mode,
  output logic [NPART-2:0] bnd_mask
);
  localparam int unsigned IW = $clog2(NPART) + 2;

  logic [IW-1:0] grp_m;

  always_comb begin
    grp_m = IW'(simd_slice_pkg::parts_per_elem(mode) - 1);
  end

  // A boundary after partition b is an element edge when b+1 is a multiple
  // of the group size.
  for (genvar b = 0; b < NPART - 1; b++) begin : g_bnd
    always_comb begin
      bnd_mask[b] = ((IW'(b + 1) & grp_m) == '0);
    end
  end

endmodule

// File: rtl/simd_field_route.sv
module simd_field_route #(
  parameter int unsigned NPART  = 8,
  parameter int unsigned PART_W = 8,
  parameter int unsigned SL_LO  = 3,
  parameter int unsigned SW     = 3
) (
  input  logic [NPART*PART_W-1:0] din,
  input  logic [NPART-2:0]        bnd_mask,
  output logic [NPART*SW-1:0]     fields
);

  logic unused_din_bits;
  assign unused_din_bits = ^din;

  for (genvar p = 0; p < NPART; p++) begin : g_fld
    logic lead;
    if (p == 0) begin : g_first
      assign lead = 1'b1;
    end else begin : g_rest
      assign lead = bnd_mask[p-1];
    end

    always_comb begin
      if (lead) fields[p*SW +: SW] = din[p*PART_W + SL_LO +: SW];
      else      fields[p*SW +: SW] = '0;
    end
  end

endmodule

// File: rtl/simd_out_stage.sv
module simd_out_stage #(
  parameter int unsigned W       = 8,
  parameter bit          OUT_REG = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  if (OUT_REG) begin : g_reg
    logic [W-1:0] q_r, q_nxt;

    always_comb begin
      q_nxt = q_r;
      if (en) q_nxt = d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_r <= '0;
      else        q_r <= q_nxt;
    end

    assign q = q_r;
  end else begin : g_pass
    logic unused_ctl;
    assign unused_ctl = clk ^ rst_n ^ en;
    assign q = d;
  end

endmodule

// File: rtl/simd_lane_slicer.sv
module simd_lane_slicer #(
  parameter int unsigned NPART   = 8,
  parameter int unsigned PART_W  = 8,
  parameter int unsigned SL_LO   = 3,
  parameter int unsigned SL_HI   = 6,
  parameter bit          OUT_REG = 1'b1
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [1:0]                        mode,
  input  logic [NPART*PART_W-1:0]           din,
  output logic [NPART*(SL_HI-SL_LO)-1:0]    dout,
  output logic [NPART-2:0]                  part_mask
);
  import simd_slice_pkg::*;

  localparam int unsigned SW  = SL_HI - SL_LO;
  localparam int unsigned DW  = NPART * SW;
  localparam int unsigned MW  = NPART - 1;
  localparam int unsigned OW  = DW + MW;

  initial begin
    assert (SL_LO < SL_HI && SL_HI <= PART_W && NPART >= 8)
      else $error("slice bounds must lie inside one partition");
  end

  logic [MW-1:0] bnd_mask;
  logic [DW-1:0] fields;
  logic [OW-1:0] stage_q;

  simd_part_mask #(.NPART(NPART)) u_mask (
    .mode     (mode),
    .bnd_mask (bnd_mask)
  );

  simd_field_route #(
    .NPART (NPART), .PART_W(PART_W), .SL_LO(SL_LO), .SW(SW)
  ) u_route (
    .din      (din),
    .bnd_mask (bnd_mask),
    .fields   (fields)
  );

  simd_out_stage #(.W(OW), .OUT_REG(OUT_REG)) u_stage (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (1'b1),
    .d     ({bnd_mask, fields}),
    .q     (stage_q)
  );

  assign dout      = stage_q[DW-1:0];
  assign part_mask = stage_q[OW-1:DW];

  if (OUT_REG) begin : g_chk
    assert_field0_R2: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> dout[SW-1:0] == $past(din[SL_LO +: SW]));

    assert_top_byte_R3: assert property (@(posedge clk) disable iff (!rst_n)
      mode == EW8 |=> dout[(NPART-1)*SW +: SW] == $past(din[(NPART-1)*PART_W + SL_LO +: SW]));

    assert_pad_32_R5: assert property (@(posedge clk) disable iff (!rst_n)
      mode == EW32 |=> dout[SW +: SW] == '0 && dout[4*SW +: SW] == $past(din[4*PART_W + SL_LO +: SW]));

    assert_pad_64_R6: assert property (@(posedge clk) disable iff (!rst_n)
      mode == EW64 |=> (dout >> SW) == '0);

    assert_mask_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> $countones(part_mask) == (NPART >> $past(mode)) - 1);

    assert_reset_clear_R8: assert property (@(posedge clk)
      !rst_n |-> dout == '0 && part_mask == '0);
  end

endmodule

// File: tb/test_simd_lane_slicer.sv
`timescale 1ns/1ps
module test_simd_lane_slicer;
  localparam int LO = 3;
  localparam int SW = 3;

  logic        clk;
  logic        rst_n;
  logic [1:0]  mode;
  logic [63:0] din;
  logic [23:0] dout;
  logic [6:0]  part_mask;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic [1:0]  prv_mode;
  logic [63:0] prv_din;
  string       prv_tag;
  bit          have_prv = 0;

  simd_lane_slicer i_simd_lane_slicer (
    .clk(clk), .rst_n(rst_n), .mode(mode), .din(din),
    .dout(dout), .part_mask(part_mask)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [23:0] ref_out(input logic [1:0] m, input logic [63:0] d);
    logic [23:0] r = '0;
    int ew  = 8 << m;
    int num = 64 / ew;
    for (int e = 0; e < num; e++) begin
      int fld = e * (1 << m);
      r[fld*SW +: SW] = d[e*ew + LO +: SW];
    end
    return r;
  endfunction

  function automatic logic [6:0] ref_mask(input logic [1:0] m);
    logic [6:0] r;
    for (int b = 0; b < 7; b++) r[b] = (((b + 1) % (1 << m)) == 0);
    return r;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_prev();
    if (have_prv) begin
      chk(prv_tag, 32'(dout), 32'(ref_out(prv_mode, prv_din)));
      chk("R2", 32'(dout[SW-1:0]), 32'(prv_din[LO +: SW]));
      chk("R7", 32'(part_mask), 32'(ref_mask(prv_mode)));
    end
  endtask

  task automatic step(input logic [1:0] m, input logic [63:0] d, input string tag);
    @(negedge clk);
    check_prev();
    mode = m; din = d;
    prv_mode = m; prv_din = d; prv_tag = tag; have_prv = 1;
  endtask

  function automatic string mode_tag(input logic [1:0] m);
    case (m)
      2'd0: return "R3";
      2'd1: return "R4";
      2'd2: return "R5";
      default: return "R6";
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] outside;
    rst_n = 1'b1; mode = 2'd0; din = 64'hFFFF_FFFF_FFFF_FFFF;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R8: reset clears both outputs
    chk("R8", 32'(dout), 32'h0);
    chk("R8", 32'(part_mask), 32'h0);
    // R1: output width and field count
    chk("R1", 32'($bits(dout)), 32'd24);
    rst_n = 1'b1;

    // R8: registered latency - output still old right after input change
    @(negedge clk);
    mode = 2'd1; din = 64'h0123_4567_89AB_CDEF;
    #1 chk("R8", 32'(dout), 32'(ref_out(2'd0, 64'hFFFF_FFFF_FFFF_FFFF)));
    prv_mode = mode; prv_din = din; prv_tag = "R8"; have_prv = 1;

    // all-ones in every mode
    for (int m = 0; m < 4; m++) step(2'(m), 64'hFFFF_FFFF_FFFF_FFFF, mode_tag(2'(m)));

    // R9: only bits outside each slice set -> zero data
    outside = '1;
    for (int p = 0; p < 8; p++) outside[p*8 + LO +: SW] = '0;
    for (int m = 0; m < 4; m++) step(2'(m), outside, "R9");

    // walking single bit through every position, each mode
    for (int m = 0; m < 4; m++)
      for (int i = 0; i < 64; i++) step(2'(m), 64'd1 << i, mode_tag(2'(m)));

    // random words, mode changing every cycle
    for (int i = 0; i < 400; i++) begin
      logic [1:0] m = 2'($urandom_range(0, 3));
      step(m, {$urandom, $urandom}, mode_tag(m));
    end

    @(negedge clk);
    check_prev();

    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule